// File: doc/BRIEF.md
# Reciprocal Square-Root Lookup Unit

This unit produces a fixed-point reciprocal square root for one signed 16-bit element of a vector register. It is started with a decoded vector instruction word and the eight 16-bit elements of the chosen source register. It picks the operand element and takes its magnitude. It normalizes the magnitude by its count of leading zeros and builds a 10-bit address for an external 16-bit lookup ROM. The returned entry is then rescaled by half of the inverted shift count. Negative operands have their result inverted. Zero and the most negative value get fixed saturated codes.

On completion the unit presents the 32-bit result. It also presents the low 16 bits with the destination lane and register for a register-file write. A broadcast copy of the source elements is presented for the accumulator's low lanes. Two further function codes are no-operations that complete without writing. Any other encoding completes with an illegal-instruction flag and no writes. One operation can be started every cycle.

Top module: `rsq_unit`

## Requirements
- R1: An instruction is a reciprocal-square-root operation when bits 31:26 equal 010010, bit 25 is 1 and the function code in bits 5:0 is 0x34. Bits 24:21 hold the element selector, 15:11 the destination element and 10:6 the destination register.
- R2: The operand is source element number `selector[2:0]` (element k occupies `src_vec[16k+15:16k]`). `lane_idx` equals `instr[13:11]` and `dst_reg` equals `instr[10:6]`.
- R3: In the cycle after a start is sampled, `rom_addr` is `{1, n[30:23], s[0]}`. Here s is the leading-zero count of the 32-bit zero-extended operand magnitude (0 for a zero magnitude) and n is the magnitude shifted left by s.
- R4: For a positive operand, `result` = (0x40000000 | entry<<14) >> ((31 - s) / 2), where entry is the ROM word read at that address.
- R5: For a negative operand other than 0x8000, `result` is the bitwise inverse of the R4 value.
- R6: A zero operand gives `result` = 0x7FFFFFFF.
- R7: An operand of 0x8000 gives `result` = 0xFFFF0000.
- R8: On completion of the operation `lane_we` is 1 and `lane_data` equals `result[15:0]`.
- R9: On completion `acc_we` is 1 and accumulator lane i carries source element p(i), where e is the 4-bit selector. For e < 2, p(i) = i. For e of 2 or 3, p(i) = 2*(i/2) + (e-2). For e from 4 to 7, p(i) = 4*(i/4) + (e-4). For e of 8 or more, p(i) = e-8.
- R10: With a valid major opcode and bit 25 set, function codes 0x37 and 0x3F complete with `done` but leave `lane_we`, `acc_we` and `illegal` at 0.
- R11: Any other encoding completes with `done` and `illegal` at 1, and `lane_we` and `acc_we` at 0.
- R12: `done` is 1 in exactly the cycle three clock edges after each sampled `start`, and at no other time. Outside `done`, the write enables and `illegal` are 0. A start is accepted every cycle.
- R13: During and straight after reset, `done`, `illegal`, `lane_we`, `acc_we`, `result` and `rom_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept `instr` and `src_vec` this cycle |
| instr | input | 32 | Vector instruction word |
| src_vec | input | 128 | Eight 16-bit source elements |
| rom_addr | output | 10 | Lookup ROM address |
| rom_data | input | 16 | ROM word, valid one cycle after its address |
| done | output | 1 | Operation complete |
| illegal | output | 1 | Unrecognized encoding, qualified by `done` |
| lane_we | output | 1 | Write `lane_data` to the destination element |
| lane_idx | output | 3 | Destination element index |
| dst_reg | output | 5 | Destination register number |
| lane_data | output | 16 | Low 16 bits of the result |
| result | output | 32 | Full reciprocal square-root value |
| acc_we | output | 1 | Write `acc_low` to the accumulator low lanes |
| acc_low | output | 128 | Broadcast source elements for the accumulator |

## Verification
The front stage can condition a newly started operand and form its ROM address in the same cycle that the back stage rebuilds and writes an earlier operation's result. A no-operation or illegal encoding can also finish while a lookup is still in flight behind it. The bench provokes this overlap with back-to-back starts that mix all three kinds, random operands and selectors, and random idle gaps. Every clock, it compares `done`, the enables, the result fields and the ROM address against a queue of expected completions, each due three edges after its start.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  localparam logic [5:0] MAJOR_VEC = 6'b010010;
  localparam logic [5:0] FN_RSQ    = 6'h34;
  localparam logic [5:0] FN_NOP    = 6'h37;
  localparam logic [5:0] FN_NULL   = 6'h3F;

  typedef enum logic [1:0] {K_RSQ = 2'd0, K_NOP = 2'd1, K_BAD = 2'd2} kind_e;

  typedef struct packed {
    kind_e       kind;
    logic [3:0]  esel;
    logic [2:0]  lane;
    logic [4:0]  vd;
  } dec_t;

  typedef struct packed {
    kind_e       kind;
    logic        neg;
    logic        zero;
    logic        minv;
    logic [4:0]  shift;
    logic [2:0]  lane;
    logic [4:0]  vd;
  } stage_t;

  // leading zeros of a 32-bit word; an all-zero word reports 0
  function automatic logic [4:0] lead_zeros(input logic [31:0] v);
    logic [4:0] n;
    logic       found;
    n = '0;
    found = 1'b0;
    for (int i = 31; i >= 0; i--) begin
      if (!found && v[i]) begin
        n = 5'(31 - i);
        found = 1'b1;
      end
    end
    return n;
  endfunction

  function automatic logic [9:0] table_addr(input logic [31:0] mag, input logic [4:0] sh);
    return {1'b1, 8'((mag << sh) >> 23), sh[0]};
  endfunction

  function automatic logic [31:0] rebuild(input logic [15:0] entry, input logic [4:0] sh,
                                          input logic neg, input logic zero, input logic minv);
    logic [31:0] base;
    logic [4:0]  inv;
    logic [31:0] t;
    base = 32'h4000_0000 | {2'b00, entry, 14'b0};
    inv  = ~sh;
    t    = base >> inv[4:1];
    if (neg)       t = ~t;
    if (zero)      t = 32'h7FFF_FFFF;
    else if (minv) t = 32'hFFFF_0000;
    return t;
  endfunction

  // which source element feeds accumulator lane 'lane'
  function automatic logic [2:0] lane_pick(input logic [3:0] esel, input logic [2:0] lane);
    if (esel[3])      return esel[2:0];
    else if (esel[2]) return {lane[2], esel[1:0]};
    else if (esel[1]) return {lane[2:1], esel[0]};
    else              return lane;
  endfunction

endpackage

// File: rtl/rsq_decode.sv
module rsq_decode
  import rsq_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);
  logic major_ok;
  logic unused_fields;

  assign major_ok      = (instr[31:26] == MAJOR_VEC) && instr[25];
  assign unused_fields = ^instr[20:14];

  always_comb begin
    dec.esel = instr[24:21];
    dec.lane = instr[13:11];
    dec.vd   = instr[10:6];
    if (major_ok && instr[5:0] == FN_RSQ)
      dec.kind = K_RSQ;
    else if (major_ok && (instr[5:0] == FN_NOP || instr[5:0] == FN_NULL))
      dec.kind = K_NOP;
    else
      dec.kind = K_BAD;
  end
endmodule

// File: rtl/rsq_front.sv
module rsq_front
  import rsq_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int ELEM_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  dec_t                      dec,
  input  logic [LANES*ELEM_W-1:0]   src_vec,
  output logic                      s1_valid,
  output stage_t                    s1,
  output logic [LANES*ELEM_W-1:0]   s1_acc,
  output logic [9:0]                rom_addr
);
  localparam int VEC_W = LANES * ELEM_W;

  logic [ELEM_W-1:0] operand;
  logic [ELEM_W-1:0] abs_val;
  logic [31:0]       mag;
  stage_t            nxt;
  logic [VEC_W-1:0]  acc_next;
  logic [9:0]        addr_next;

  assign operand = src_vec[dec.esel[2:0]*ELEM_W +: ELEM_W];
  assign abs_val = operand[ELEM_W-1] ? ELEM_W'(~operand + 1'b1) : operand;
  assign mag     = 32'(abs_val);

  always_comb begin
    nxt.kind  = dec.kind;
    nxt.neg   = operand[ELEM_W-1];
    nxt.zero  = (operand == '0);
    nxt.minv  = operand[ELEM_W-1] && (operand[ELEM_W-2:0] == '0);
    nxt.shift = lead_zeros(mag);
    nxt.lane  = dec.lane;
    nxt.vd    = dec.vd;
  end

  assign addr_next = table_addr(mag, nxt.shift);

  for (genvar g = 0; g < LANES; g++) begin : g_bcast
    logic [2:0] pick;
    assign pick = lane_pick(dec.esel, 3'(g));
    assign acc_next[g*ELEM_W +: ELEM_W] = src_vec[pick*ELEM_W +: ELEM_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1       <= '0;
      s1_acc   <= '0;
      rom_addr <= '0;
    end else begin
      s1_valid <= start;
      if (start) begin
        s1       <= nxt;
        s1_acc   <= acc_next;
        rom_addr <= addr_next;
      end
    end
  end

  // R3: a live lookup carries a normalized magnitude, so its shift is at least 16
  a_r3_shift_range: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1.kind == K_RSQ && !s1.zero) |-> (s1.shift >= 5'd16));
endmodule

// File: rtl/rsq_back.sv
module rsq_back
  import rsq_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int ELEM_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      s1_valid,
  input  stage_t                    s1,
  input  logic [LANES*ELEM_W-1:0]   s1_acc,
  input  logic [15:0]               rom_data,
  output logic                      done,
  output logic                      illegal,
  output logic                      lane_we,
  output logic [2:0]                lane_idx,
  output logic [4:0]                dst_reg,
  output logic [15:0]               lane_data,
  output logic [31:0]               result,
  output logic                      acc_we,
  output logic [LANES*ELEM_W-1:0]   acc_low
);
  logic                    s2_valid;
  stage_t                  s2;
  logic [LANES*ELEM_W-1:0] s2_acc;
  logic                    s2_is_rsq;
  logic [31:0]             shaped;

  assign s2_is_rsq = s2_valid && s2.kind == K_RSQ;
  assign shaped    = rebuild(rom_data, s2.shift, s2.neg, s2.zero, s2.minv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid  <= 1'b0;
      s2        <= '0;
      s2_acc    <= '0;
      done      <= 1'b0;
      illegal   <= 1'b0;
      lane_we   <= 1'b0;
      acc_we    <= 1'b0;
      lane_idx  <= '0;
      dst_reg   <= '0;
      lane_data <= '0;
      result    <= '0;
      acc_low   <= '0;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) begin
        s2     <= s1;
        s2_acc <= s1_acc;
      end
      done    <= s2_valid;
      illegal <= s2_valid && s2.kind == K_BAD;
      lane_we <= s2_is_rsq;
      acc_we  <= s2_is_rsq;
      if (s2_is_rsq) begin
        result    <= shaped;
        lane_data <= shaped[15:0];
        lane_idx  <= s2.lane;
        dst_reg   <= s2.vd;
        acc_low   <= s2_acc;
      end
    end
  end

  a_r6_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_is_rsq && s2.zero) |=> (result == 32'h7FFF_FFFF));
  a_r5_neg_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_is_rsq && s2.neg) |=> result[31]);
  a_r4_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_is_rsq && !s2.neg && !s2.zero) |=> (!result[31] && result >= 32'h0080_0000));
  a_r11_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!lane_we && !acc_we));
  a_r10_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && s2.kind == K_NOP) |=> (done && !lane_we && !acc_we && !illegal));
endmodule

// File: rtl/rsq_unit.sv
module rsq_unit
  import rsq_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int ELEM_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [31:0]               instr,
  input  logic [LANES*ELEM_W-1:0]   src_vec,
  output logic [9:0]                rom_addr,
  input  logic [15:0]               rom_data,
  output logic                      done,
  output logic                      illegal,
  output logic                      lane_we,
  output logic [2:0]                lane_idx,
  output logic [4:0]                dst_reg,
  output logic [15:0]               lane_data,
  output logic [31:0]               result,
  output logic                      acc_we,
  output logic [LANES*ELEM_W-1:0]   acc_low
);
  dec_t                    dec;
  logic                    s1_valid;
  stage_t                  s1;
  logic [LANES*ELEM_W-1:0] s1_acc;

  rsq_decode u_dec (.instr(instr), .dec(dec));

  rsq_front #(.LANES(LANES), .ELEM_W(ELEM_W)) u_front (
    .clk(clk), .rst_n(rst_n), .start(start), .dec(dec), .src_vec(src_vec),
    .s1_valid(s1_valid), .s1(s1), .s1_acc(s1_acc), .rom_addr(rom_addr)
  );

  rsq_back #(.LANES(LANES), .ELEM_W(ELEM_W)) u_back (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1(s1), .s1_acc(s1_acc),
    .rom_data(rom_data), .done(done), .illegal(illegal), .lane_we(lane_we),
    .lane_idx(lane_idx), .dst_reg(dst_reg), .lane_data(lane_data), .result(result),
    .acc_we(acc_we), .acc_low(acc_low)
  );

  a_r12_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ##3 done);
  a_r12_no_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start, 3));
  a_r8_enables_paired: assert property (@(posedge clk) disable iff (!rst_n)
    lane_we |-> (acc_we && done));
endmodule

// File: tb/rsq_unit_tb.sv
module rsq_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [31:0]  instr = '0;
  logic [127:0] src_vec = '0;
  logic [9:0]   rom_addr;
  logic [15:0]  rom_data = '0;
  logic         done, illegal, lane_we, acc_we;
  logic [2:0]   lane_idx;
  logic [4:0]   dst_reg;
  logic [15:0]  lane_data;
  logic [31:0]  result;
  logic [127:0] acc_low;

  int checks = 0;
  int fails = 0;
  int edge_n = 0;
  bit mon_on = 1'b0;

  typedef struct {
    int           due;
    int           kind;
    logic [31:0]  res;
    logic [2:0]   lane;
    logic [4:0]   vd;
    logic [127:0] acc;
    string        tag;
  } exp_t;
  typedef struct {
    int         due;
    logic [9:0] addr;
  } aexp_t;
  exp_t  q[$];
  aexp_t aq[$];

  always #2.5 clk = ~clk;

  rsq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .src_vec(src_vec),
    .rom_addr(rom_addr), .rom_data(rom_data), .done(done), .illegal(illegal),
    .lane_we(lane_we), .lane_idx(lane_idx), .dst_reg(dst_reg), .lane_data(lane_data),
    .result(result), .acc_we(acc_we), .acc_low(acc_low)
  );

  function automatic logic [15:0] rom_val(input int a);
    return 16'(((a * 40503) ^ (a >> 3) ^ 11291) & 65535);
  endfunction

  always @(posedge clk) begin
    rom_data <= rom_val(int'(rom_addr));
    edge_n   <= edge_n + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (edge %0d)", req, act, exp, edge_n);
    end
  endtask

  function automatic int ref_shift(input longint m);
    int s;
    longint t;
    if (m == 0) return 0;
    s = 31;
    t = m;
    while (t > 1) begin
      t = t >> 1;
      s--;
    end
    return s;
  endfunction

  function automatic logic [9:0] ref_addr(input int v);
    longint m;
    longint nrm;
    int s;
    m = (v < 0) ? -v : v;
    s = ref_shift(m);
    nrm = (m << s) & 64'hFFFF_FFFF;
    return 10'(512 + ((nrm >> 23) & 255) * 2 + (s % 2));
  endfunction

  function automatic logic [31:0] ref_res(input int v);
    longint m;
    longint base;
    longint r;
    int s;
    if (v == 0) return 32'h7FFF_FFFF;
    if (v == -32768) return 32'hFFFF_0000;
    m = (v < 0) ? -v : v;
    s = ref_shift(m);
    base = 64'h4000_0000 + longint'(rom_val(int'(ref_addr(v)))) * 16384;
    r = base >> ((31 - s) / 2);
    if (v < 0) r = ~r;
    return 32'(r & 64'hFFFF_FFFF);
  endfunction

  function automatic string res_tag(input int v);
    if (v == 0) return "R6";
    if (v == -32768) return "R7";
    if (v < 0) return "R5";
    return "R4";
  endfunction

  // R1 field layout used for building words
  function automatic logic [31:0] mk(input logic [5:0] major, input logic b25, input logic [3:0] e,
                                     input logic [4:0] de, input logic [4:0] vd, input logic [5:0] fn);
    return {major, b25, e, 5'd3, de, vd, fn};
  endfunction

  task automatic issue(input logic [31:0] w, input logic [127:0] src);
    exp_t  e;
    aexp_t a;
    int    kind;
    int    v;
    int    es;
    @(negedge clk);
    start   = 1'b1;
    instr   = w;
    src_vec = src;
    es = int'(w[24:21]);
    v  = int'($signed(src[(es % 8) * 16 +: 16]));
    if (w[31:26] == 6'b010010 && w[25] && w[5:0] == 6'h34) kind = 0;
    else if (w[31:26] == 6'b010010 && w[25] && (w[5:0] == 6'h37 || w[5:0] == 6'h3F)) kind = 1;
    else kind = 2;
    e.due  = edge_n + 3;
    e.kind = kind;
    e.res  = ref_res(v);
    e.lane = w[13:11];
    e.vd   = w[10:6];
    e.tag  = res_tag(v);
    for (int i = 0; i < 8; i++) begin
      int p;
      if (es < 2) p = i;
      else if (es < 4) p = (i / 2) * 2 + (es - 2);
      else if (es < 8) p = (i / 4) * 4 + (es - 4);
      else p = es - 8;
      e.acc[i*16 +: 16] = src[p*16 +: 16];
    end
    q.push_back(e);
    if (kind == 0) begin
      a.due  = edge_n + 1;
      a.addr = ref_addr(v);
      aq.push_back(a);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  function automatic logic [127:0] mk_src(input logic [3:0] e, input logic [15:0] v);
    logic [127:0] s;
    for (int i = 0; i < 4; i++) s[i*32 +: 32] = $urandom;
    s[int'(e[2:0])*16 +: 16] = v;
    return s;
  endfunction

  // per-cycle comparison against the expectation queues
  always @(negedge clk) begin
    if (mon_on) begin
      if (aq.size() > 0 && aq[0].due == edge_n) begin
        aexp_t a;
        a = aq.pop_front();
        chk(rom_addr == a.addr, "R3", 128'(rom_addr), 128'(a.addr));
      end
      if (q.size() > 0 && q[0].due == edge_n) begin
        exp_t e;
        e = q.pop_front();
        chk(done == 1'b1, "R12", 128'(done), 128'd1);
        if (e.kind == 0) begin
          chk(result == e.res, e.tag, 128'(result), 128'(e.res));
          chk(lane_we && lane_data == e.res[15:0], "R8", 128'(lane_data), 128'(e.res[15:0]));
          chk(lane_idx == e.lane && dst_reg == e.vd, "R2", 128'({lane_idx, dst_reg}), 128'({e.lane, e.vd}));
          chk(acc_we && acc_low == e.acc, "R9", acc_low, e.acc);
          chk(!illegal, "R1", 128'(illegal), 128'd0);
        end else if (e.kind == 1) begin
          chk(!lane_we && !acc_we && !illegal, "R10", 128'({lane_we, acc_we, illegal}), 128'd0);
        end else begin
          chk(illegal && !lane_we && !acc_we, "R11", 128'({lane_we, acc_we, illegal}), 128'b001);
        end
      end else begin
        chk(!done && !lane_we && !acc_we && !illegal, "R12",
            128'({done, lane_we, acc_we, illegal}), 128'd0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    int vals[14];
    vals = '{1, 2, 3, 255, 256, 16384, 32767, -1, -2, -300, 0, -32768, -32767, 12345};
    repeat (3) @(negedge clk);
    chk(!done && !illegal && !lane_we && !acc_we && result == 0 && rom_addr == 0, "R13",
        128'({done, illegal, lane_we, acc_we, result, rom_addr}), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !illegal && !lane_we && !acc_we && result == 0 && rom_addr == 0, "R13",
        128'({done, illegal, lane_we, acc_we, result, rom_addr}), 128'd0);
    mon_on = 1'b1;

    // R4 R5 R6 R7: directed operands, back to back, varied selectors
    foreach (vals[i]) begin
      logic [3:0] e;
      e = 4'(i);
      issue(mk(6'b010010, 1'b1, e, 5'(i + 8), 5'(31 - i), 6'h34), mk_src(e, 16'(vals[i])));
    end
    idle(5);

    // R10 R11 overlapping with lookups in flight
    issue(mk(6'b010010, 1'b1, 4'd5, 5'd2, 5'd7, 6'h34), mk_src(4'd5, 16'h0123));
    issue(mk(6'b010010, 1'b1, 4'd5, 5'd2, 5'd7, 6'h37), mk_src(4'd5, 16'h0010));
    issue(mk(6'b010010, 1'b1, 4'd1, 5'd4, 5'd9, 6'h3F), mk_src(4'd1, 16'h0020));
    issue(mk(6'b010011, 1'b1, 4'd1, 5'd4, 5'd9, 6'h34), mk_src(4'd1, 16'h0030));
    issue(mk(6'b010010, 1'b0, 4'd1, 5'd4, 5'd9, 6'h34), mk_src(4'd1, 16'h0040));
    issue(mk(6'b010010, 1'b1, 4'd2, 5'd4, 5'd9, 6'h35), mk_src(4'd2, 16'hFF00));
    issue(mk(6'b010010, 1'b1, 4'd3, 5'd6, 5'd1, 6'h34), mk_src(4'd3, 16'h8000));
    idle(5);

    // R9: every selector value
    for (int e = 0; e < 16; e++)
      issue(mk(6'b010010, 1'b1, 4'(e), 5'(e), 5'(e), 6'h34), mk_src(4'(e), 16'($urandom)));
    idle(4);

    // mixed random traffic with gaps
    for (int n = 0; n < 400; n++) begin
      logic [5:0] fn;
      logic [3:0] e;
      int r;
      r = int'($urandom % 16);
      fn = (r < 11) ? 6'h34 : (r == 11) ? 6'h37 : (r == 12) ? 6'h3F : 6'($urandom);
      e = 4'($urandom);
      issue(mk(6'b010010, (r != 13), e, 5'($urandom), 5'($urandom), fn), mk_src(e, 16'($urandom)));
      if ($urandom % 4 == 0) idle(int'($urandom % 4) + 1);
    end
    idle(6);
    chk(q.size() == 0 && aq.size() == 0, "R12", 128'(q.size()), 128'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule